// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing half of a byte-wide serial EEPROM. It sits behind a two-wire I2C bus and takes a system clock that runs many times faster than SCL. Both bus lines pass through a synchronizer. The engine finds start, stop and repeated-start conditions, decodes the device control byte, takes in a two-byte word address and serves current-address, random and sequential reads from a 64 KiB array. The array has a simple synchronous read port. SDA is an open-drain pin: the engine asserts `sda_oe` to pull the line low and otherwise leaves it released.

Writes are not committed here. Each received data byte goes out on a one-cycle push strobe together with its target address. A separate page-buffer block collects the bytes and runs the timed program cycle. That block is told to start by a commit strobe on the stop, or to drop the bytes by an abort strobe when a repeated start ends the command. While it reports busy, the engine refuses every control byte, so a bus master can poll for completion.

The engine keeps the internal address pointer. Reads wrap inside the 32 KiB half the pointer is in. Writes wrap inside the current 64-byte page.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A control byte is acknowledged only when its bits 7..4 equal 1010b and its bits 2..1 equal `strap_cs[1:0]`. Bit 3 is the block bit and bit 0 is R/W (1 = read). A refused control byte gets no acknowledge, and the engine ignores all later bytes until the next start.
- R2: While `wr_busy` is high when the eighth bit of a control byte arrives, that control byte is not acknowledged, even if it matches.
- R3: In a write command, bit 3 of the control byte gives pointer bit 15. Bit 7 of the first address byte is ignored, and its bits 6..0 give pointer bits 14..8. The second address byte gives bits 7..0.
- R4: Each data byte of a write is acknowledged and pushed with the current pointer as its address. The pointer then advances only in its low 6 bits, so it wraps within its 64-byte page.
- R5: A stop after at least one pushed data byte pulses `wr_commit` once. A repeated start after pushed data pulses `wr_abort` instead. A command that carried only an address pushes and commits nothing, and it leaves the pointer loaded.
- R6: A read control byte is acknowledged, and the engine then sends, MSB first, the array byte at the pointer, fetched through `mem_rd`/`mem_addr`.
- R7: Each master ACK after a read byte makes the engine send the next byte. After a master NACK the engine releases SDA and drives nothing more until a new start.
- R8: In reads the pointer steps from 7FFFh to 0000h and from FFFFh to 8000h, and it never changes bit 15.
- R9: After any read or write, the pointer holds the address that follows the last byte transferred.
- R10: `sda_oe` changes only while SCL is low, and only after SCL has been low for at least `HOLD_CYC` system clocks.
- R11: A start or stop in the middle of a byte aborts the transfer. A start restarts control-byte reception. A stop returns the engine to idle and leaves the pointer unchanged.
- R12: After reset `sda_oe` is low, all strobes are low and the pointer is 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Level driven on SDA when enabled (always 0) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| strap_cs | input | 2 | Chip-select strap compared with control bits 2..1 |
| mem_rd | output | 1 | One-cycle array read strobe |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_rd` |
| wr_busy | input | 1 | Page-buffer block is running a program cycle |
| wr_push | output | 1 | One-cycle strobe: a write data byte is ready |
| wr_addr | output | ADDR_W | Target address of the pushed byte |
| wr_data | output | 8 | Pushed data byte |
| wr_commit | output | 1 | One-cycle strobe: start the program cycle |
| wr_abort | output | 1 | One-cycle strobe: discard the pushed bytes |

## Verification
The assertions watch, on every cycle, the properties that need only local state. SDA drive changes only while SCL is low, a stop never moves the pointer, a busy page buffer always means a refused control byte, each read fetch keeps the pointer in its 32 KiB half, and at most one memory or write strobe fires at a time. Only the bench scenarios can show that the right bytes come out. That covers the exact address produced from the control and address bytes, the two read wrap points, page wrap on writes, pointer carry-over between commands, and which of commit or abort a command ends with. The same holds for recovery after transfers cut off mid-byte, and for silence after a master NACK.

// File: rtl/ees_pkg.sv
package ees_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } ees_state_e;

   typedef enum logic [1:0] {
      RX_CTRL,
      RX_AHI,
      RX_ALO,
      RX_DATA
   } ees_rx_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/ees_line_sync.sv
module ees_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("ees_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] scl_pipe, sda_pipe;
   logic         scl_prev, sda_prev;

   // Bus idles high, so the pipeline resets to ones and no false edge appears.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
         sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
         scl_prev <= scl_pipe[TOP];
         sda_prev <= sda_pipe[TOP];
      end
   end

   assign scl_lvl   = scl_pipe[TOP];
   assign sda_lvl   = sda_pipe[TOP];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ees_addr_step.sv
module ees_addr_step #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 6,
   parameter int HALF_WRAP = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] seq_next,
   output logic [ADDR_W-1:0] page_next
);
   localparam logic [PAGE_W-1:0]   PG_ONE  = PAGE_W'(1);
   localparam logic [ADDR_W-2:0]   LOW_ONE = (ADDR_W - 1)'(1);
   localparam logic [ADDR_W-1:0]   ALL_ONE = ADDR_W'(1);

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("ees_addr_step: PAGE_W must be in 1..ADDR_W-1");
      end
      if (HALF_WRAP != 0) begin : g_half
         // Top bit frozen: reads stay inside the current half of the array.
         assign seq_next = {addr[ADDR_W-1], addr[ADDR_W-2:0] + LOW_ONE};
      end else begin : g_full
         assign seq_next = addr + ALL_ONE;
      end
   endgenerate

   assign page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
endmodule

// File: rtl/ees_sda_hold.sv
module ees_sda_hold #(
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic want_low,
   output logic sda_oe
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
   localparam logic [CW-1:0] ONE_V  = CW'(1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("ees_sda_hold: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_run <= '0;
         sda_oe  <= 1'b0;
      end else begin
         if (scl_lvl)
            low_run <= '0;
         else if (low_run != HOLD_V)
            low_run <= low_run + ONE_V;
         if (!scl_lvl && low_run == HOLD_V)
            sda_oe <= want_low;
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sda_oe != $past(sda_oe)) |-> (!scl_lvl && !$past(scl_lvl))) else $error("SDA drive moved while SCL high"); // R10
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
   import ees_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int PAGE_W      = 6,
   parameter int HOLD_CYC    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int HALF_WRAP   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_oe,
   input  logic [1:0]        strap_cs,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   input  logic              wr_busy,
   output logic              wr_push,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              wr_abort
);
   localparam int HI_W = ADDR_W - 9;
   localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

   generate
      if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr
         $error("eeprom_i2c_slave: ADDR_W must be in 10..16");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   ees_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   ees_state_e        state;
   ees_rx_e           kind;
   logic [2:0]        bit_cnt;
   logic [7:0]        shreg, tx_sh;
   logic              byte_done, go_tx, mack, data_seen, want_low, rd_cap;
   logic              blk_q;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] ptr_q, seq_nx, page_nx;
   logic [7:0]        rx_byte;
   logic              ctrl_hit;

   ees_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HALF_WRAP(HALF_WRAP)) u_step (
      .addr(ptr_q), .seq_next(seq_nx), .page_next(page_nx)
   );

   ees_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .want_low(want_low), .sda_oe(sda_oe)
   );

   assign rx_byte  = {shreg[6:0], sda_lvl};
   assign ctrl_hit = (rx_byte[7:4] == DEV_CODE) && (rx_byte[2:1] == strap_cs);
   assign sda_o    = 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= RX_CTRL;
         bit_cnt   <= '0;
         shreg     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
         go_tx     <= 1'b0;
         mack      <= 1'b0;
         data_seen <= 1'b0;
         want_low  <= 1'b0;
         rd_cap    <= 1'b0;
         blk_q     <= 1'b0;
         hi_q      <= '0;
         ptr_q     <= '0;
         mem_rd    <= 1'b0;
         mem_addr  <= '0;
         wr_push   <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
         wr_abort  <= 1'b0;
      end else begin
         mem_rd    <= 1'b0;
         wr_push   <= 1'b0;
         wr_commit <= 1'b0;
         wr_abort  <= 1'b0;
         rd_cap    <= mem_rd;
         if (rd_cap)
            tx_sh <= mem_rdata;

         if (stop_det) begin
            state     <= ST_IDLE;
            want_low  <= 1'b0;
            wr_commit <= data_seen;
            data_seen <= 1'b0;
         end else if (start_det) begin
            state     <= ST_RX;
            kind      <= RX_CTRL;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            want_low  <= 1'b0;
            wr_abort  <= data_seen;
            data_seen <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise && !byte_done) begin
                     shreg <= rx_byte;
                     if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        unique case (kind)
                           RX_CTRL: begin
                              if (ctrl_hit && !wr_busy) begin
                                 blk_q <= rx_byte[3];
                                 go_tx <= rx_byte[0];
                                 kind  <= RX_AHI;
                                 if (rx_byte[0]) begin
                                    mem_rd   <= 1'b1;
                                    mem_addr <= ptr_q;
                                    ptr_q    <= seq_nx;
                                 end
                              end else begin
                                 state <= ST_IDLE;
                              end
                           end
                           RX_AHI: begin
                              hi_q <= rx_byte[HI_W-1:0];
                              kind <= RX_ALO;
                           end
                           RX_ALO: begin
                              ptr_q <= {blk_q, hi_q, rx_byte};
                              kind  <= RX_DATA;
                           end
                           RX_DATA: begin
                              wr_push   <= 1'b1;
                              wr_addr   <= ptr_q;
                              wr_data   <= rx_byte;
                              ptr_q     <= page_nx;
                              data_seen <= 1'b1;
                           end
                           default: ;
                        endcase
                     end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                     end
                  end else if (scl_fall && byte_done) begin
                     state     <= ST_RACK;
                     want_low  <= 1'b1;
                     byte_done <= 1'b0;
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (go_tx) begin
                        state    <= ST_TX;
                        want_low <= ~tx_sh[7];
                     end else begin
                        state    <= ST_RX;
                        want_low <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        state    <= ST_TACK;
                        want_low <= 1'b0;
                     end else begin
                        bit_cnt  <= bit_cnt + 3'd1;
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        want_low <= ~tx_sh[6];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                     if (!sda_lvl) begin
                        mem_rd   <= 1'b1;
                        mem_addr <= ptr_q;
                        ptr_q    <= seq_nx;
                     end
                  end else if (scl_fall) begin
                     bit_cnt <= '0;
                     if (mack) begin
                        state    <= ST_TX;
                        want_low <= ~tx_sh[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RX && kind == RX_CTRL && scl_rise && !byte_done && bit_cnt == LAST_BIT && wr_busy && !start_det && !stop_det) |=> (state == ST_IDLE)) else $error("control byte taken while busy"); // R2
   AST_READ_HALF: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && HALF_WRAP != 0) |-> (ptr_q[ADDR_W-1] == mem_addr[ADDR_W-1])) else $error("read pointer left its half"); // R8
   AST_STOP_PTR: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> (ptr_q == $past(ptr_q))) else $error("stop moved the pointer"); // R11
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rd, wr_push, wr_commit, wr_abort})) else $error("strobes overlap"); // R4
   AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) wr_commit |-> (state == ST_IDLE && !data_seen)) else $error("commit outside a stop"); // R5
endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD_CYC   = 4;
   localparam int QP         = 10;
   localparam int HP         = 20;
   localparam int WD_CYCLES  = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [1:0] strap_cs = 2'b01;
   logic wr_busy = 1'b0;
   logic sda_o, sda_oe, mem_rd, wr_push, wr_commit, wr_abort;
   logic [15:0] mem_addr, wr_addr;
   logic [7:0] wr_data;
   logic [7:0] mem_rdata = 8'h00;
   wire  sda_line = sda_m & ~sda_oe;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   eeprom_i2c_slave #(.HOLD_CYC(HOLD_CYC)) i_eeprom_i2c_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .strap_cs(strap_cs),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .wr_busy(wr_busy), .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(wr_commit), .wr_abort(wr_abort)
   );

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

   int push_cnt = 0, commit_cnt = 0, abort_cnt = 0;
   logic [15:0] push_a [0:7];
   logic [7:0]  push_d [0:7];
   logic [15:0] last_rd = 16'h0;
   int low_run = 0, hold_viol = 0, oe_moves = 0;
   logic prev_oe = 1'b0;

   always @(negedge clk) begin
      if (wr_push) begin
         push_a[push_cnt % 8] = wr_addr;
         push_d[push_cnt % 8] = wr_data;
         push_cnt++;
      end
      if (wr_commit) commit_cnt++;
      if (wr_abort) abort_cnt++;
      if (mem_rd) last_rd = mem_addr;
      if (scl_m) low_run = 0; else low_run++;
      if (rst_n && sda_oe !== prev_oe) begin
         oe_moves++;
         if (scl_m || low_run < HOLD_CYC) hold_viol++;
      end
      prev_oe = sda_oe;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; idle(QP);
      scl_m = 1'b1; idle(HP);
      sda_m = 1'b0; idle(HP);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      idle(QP); sda_m = 1'b0; idle(QP);
      scl_m = 1'b1; idle(HP);
      sda_m = 1'b1; idle(HP);
   endtask

   task automatic put_bit(input logic b);
      idle(QP); sda_m = b; idle(QP);
      scl_m = 1'b1; idle(HP);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      idle(QP); sda_m = 1'b1; idle(QP);
      scl_m = 1'b1; idle(QP);
      acked = (sda_line == 1'b0);
      idle(QP); scl_m = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b, input logic give_ack);
      for (int i = 7; i >= 0; i--) begin
         idle(QP); sda_m = 1'b1; idle(QP);
         scl_m = 1'b1; idle(QP);
         b[i] = sda_line;
         idle(QP); scl_m = 1'b0;
      end
      idle(QP); sda_m = ~give_ack; idle(QP);
      scl_m = 1'b1; idle(HP);
      scl_m = 1'b0;
   endtask

   task automatic cur_read(input string req, input logic [15:0] exp_a);
      logic ak;
      logic [7:0] d;
      bus_start();
      send_byte(8'hA3, ak);
      chk(req, "read ctrl ack", ak, 1);
      get_byte(d, 1'b0);
      chk(req, "current read data", d, pat(exp_a));
      chk(req, "current read addr", last_rd, exp_a);
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R12", "sda_oe after reset", sda_oe, 0);
      chk("R12", "strobes after reset", {mem_rd, wr_push, wr_commit, wr_abort}, 0);
      chk("R12", "sda_o level", sda_o, 0);
   endtask

   task automatic t_select();
      logic ak;
      int c0 = commit_cnt;
      bus_start();
      send_byte(8'hA0, ak); chk("R1", "wrong strap refused", ak, 0);
      send_byte(8'hA2, ak); chk("R1", "ignored until start", ak, 0);
      bus_stop();
      bus_start();
      send_byte(8'hB2, ak); chk("R1", "wrong code refused", ak, 0);
      bus_stop();
      bus_start();
      send_byte(8'hA2, ak); chk("R1", "matching ctrl ack", ak, 1);
      bus_stop();
      chk("R5", "no commit without data", commit_cnt, c0);
   endtask

   task automatic t_byte_write();
      logic a0, a1, a2, a3;
      int p0 = push_cnt, c0 = commit_cnt;
      bus_start();
      send_byte(8'hAA, a0); send_byte(8'h81, a1); send_byte(8'h23, a2); send_byte(8'h5C, a3);
      bus_stop();
      chk("R4", "write acks", {a0, a1, a2, a3}, 4'hF);
      chk("R4", "one push", push_cnt - p0, 1);
      chk("R3", "push address", push_a[p0 % 8], 16'h8123);
      chk("R4", "push data", push_d[p0 % 8], 8'h5C);
      chk("R5", "commit on stop", commit_cnt - c0, 1);
   endtask

   task automatic t_busy();
      logic ak;
      wr_busy = 1'b1;
      bus_start(); send_byte(8'hA3, ak); bus_stop();
      chk("R2", "busy refuses ctrl", ak, 0);
      wr_busy = 1'b0;
   endtask

   task automatic t_page_wrap();
      logic a0, a1, a2, d0, d1, d2;
      int p0 = push_cnt;
      bus_start();
      send_byte(8'hA2, a0); send_byte(8'h00, a1); send_byte(8'h3E, a2);
      send_byte(8'h11, d0); send_byte(8'h22, d1); send_byte(8'h33, d2);
      bus_stop();
      chk("R4", "page pushes", push_cnt - p0, 3);
      chk("R4", "page addr 0", push_a[p0 % 8], 16'h003E);
      chk("R4", "page addr 1", push_a[(p0 + 1) % 8], 16'h003F);
      chk("R4", "page addr wrap", push_a[(p0 + 2) % 8], 16'h0000);
      chk("R4", "page data 2", push_d[(p0 + 2) % 8], 8'h33);
      cur_read("R9", 16'h0001);
   endtask

   task automatic t_seq_low();
      logic ak;
      logic [7:0] d;
      int p0 = push_cnt, c0 = commit_cnt;
      bus_start();
      send_byte(8'hA2, ak); send_byte(8'h7F, ak); send_byte(8'hFE, ak);
      bus_start();
      send_byte(8'hA3, ak); chk("R6", "random read ack", ak, 1);
      get_byte(d, 1'b1); chk("R7", "seq byte 7FFE", d, pat(16'h7FFE));
      get_byte(d, 1'b1); chk("R8", "seq byte 7FFF", d, pat(16'h7FFF));
      get_byte(d, 1'b0); chk("R8", "wrap to 0000", d, pat(16'h0000));
      get_byte(d, 1'b0); chk("R7", "released after NACK", d, 8'hFF);
      bus_stop();
      chk("R5", "random read pushes nothing", push_cnt - p0, 0);
      chk("R5", "random read commits nothing", commit_cnt - c0, 0);
      cur_read("R9", 16'h0001);
   endtask

   task automatic t_seq_high();
      logic ak;
      logic [7:0] d;
      bus_start();
      send_byte(8'hAA, ak); send_byte(8'hFF, ak); send_byte(8'hFF, ak);
      bus_start();
      send_byte(8'hAB, ak);
      get_byte(d, 1'b1); chk("R3", "high byte top bit ignored", d, pat(16'hFFFF));
      get_byte(d, 1'b0); chk("R8", "wrap to 8000", d, pat(16'h8000));
      bus_stop();
   endtask

   task automatic t_abort();
      logic ak;
      logic [7:0] d;
      bus_start();
      send_byte(8'hA2, ak); send_byte(8'h12, ak);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_stop();
      cur_read("R11", 16'h8001);
      bus_start();
      for (int i = 0; i < 3; i++) put_bit(1'b1);
      bus_start();
      send_byte(8'hA3, ak); chk("R11", "ctrl after mid-byte start", ak, 1);
      get_byte(d, 1'b0); chk("R11", "data after mid-byte start", d, pat(16'h8002));
      bus_stop();
   endtask

   task automatic t_rs_abort();
      logic ak;
      logic [7:0] d;
      int c0 = commit_cnt, b0 = abort_cnt;
      bus_start();
      send_byte(8'hA2, ak); send_byte(8'h01, ak); send_byte(8'h00, ak); send_byte(8'h77, ak);
      bus_start();
      chk("R5", "abort on repeated start", abort_cnt - b0, 1);
      send_byte(8'hA3, ak);
      get_byte(d, 1'b0); chk("R9", "pointer after aborted write", d, pat(16'h0101));
      bus_stop();
      chk("R5", "no commit after abort", commit_cnt - c0, 0);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_select();
      t_byte_write();
      t_busy();
      cur_read("R6", 16'h8124);
      t_page_wrap();
      t_seq_low();
      t_seq_high();
      t_abort();
      t_rs_abort();
      chk("R10", "hold violations", hold_viol, 0);
      chk("R10", "SDA was driven", (oe_moves > 0), 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule